// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Unit

This unit sits beside a processor core and turns five interrupt request lines into one request strobe with a restart address. Four of the lines have fixed restart addresses and their own sensitivity rules. One non-maskable line must see a rising edge and still be high. One line is caught on its edge. Two lines are plain level requests. A fifth, lowest-priority line stands for an external interrupt controller and carries the address that controller supplies.

Software writes a three-bit mask for the three maskable fixed lines and controls a global enable that gates every line except the non-maskable one. When the core takes an interrupt it pulses an acknowledge. This clears the edge capture of the level being served and also clears the global enable, so software has to enable interrupts again. Outputs are registered. Source and address change only on a clock edge.

Top module: `irq_vector_unit`

## Requirements
- R1: During and right after synchronous reset, req_out is 0, src_out is 0 and vec_out is 0; reset leaves all three mask bits set and the global enable clear.
- R2: Source codes on src_out are 1 non-maskable, 2 edge line, 3 mid level line, 4 low level line, 5 external; 0 means no request. When several are pending, the lowest non-zero code wins.
- R3: vec_out is 0x0024 for code 1, 0x003C for code 2, 0x0034 for code 3, 0x002C for code 4, the value of ext_vec_in for code 5, and 0 when req_out is 0.
- R4: The non-maskable line requests only after a rising edge of nmi_in while nmi_in is still high. A one-cycle pulse that has already fallen gives no request. The mask and the global enable have no effect on it.
- R5: Acknowledging the non-maskable request clears its edge capture. Holding nmi_in high afterwards gives no new request; the line has to fall and rise again.
- R6: A rising edge on hi_edge_in is captured whatever the mask or enable state, and the capture is kept after the input falls. It is cleared only when that level is acknowledged or hi_edge_clr is pulsed.
- R7: mid_lvl_in and lo_lvl_in request only while they are high; no state is kept.
- R8: mask_wr loads mask_data, where bit 2 masks the edge line, bit 1 the mid line and bit 0 the low line, and 1 means masked. The external line has no mask bit.
- R9: The global enable gates codes 2 to 5. ie_set sets it and ie_clr clears it. An effective acknowledge clears it and wins over an ie_set in the same cycle.
- R10: An ack_in sampled while req_out is 1 drives req_out to 0 on that edge. An ack_in sampled while req_out is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_in | input | 1 | Non-maskable request, edge plus level |
| hi_edge_in | input | 1 | Edge-captured maskable request |
| mid_lvl_in | input | 1 | Level maskable request, middle priority |
| lo_lvl_in | input | 1 | Level maskable request, low priority |
| ext_req_in | input | 1 | Request from external controller |
| ext_vec_in | input | VEC_W | Address supplied by external controller |
| mask_wr | input | 1 | Load mask register |
| mask_data | input | 3 | Mask value, 1 = masked |
| hi_edge_clr | input | 1 | Software clear of the edge capture |
| ie_set | input | 1 | Set global enable |
| ie_clr | input | 1 | Clear global enable |
| ack_in | input | 1 | Acknowledge from the core |
| req_out | output | 1 | Interrupt request strobe |
| src_out | output | 3 | Source code of the presented request |
| vec_out | output | VEC_W | Restart address |

## Verification
The checker watches these on every cycle: the idle outputs after reset, that the source code and the request strobe agree, the fixed address of each fixed source, that the request drops on an acknowledge, that only the non-maskable source can appear two cycles after an acknowledge, and that a non-maskable request only follows a high input. Things that depend on history are shown only by the bench scenarios. These are the edge capture that outlives its input and is cleared by software, no re-trigger of a held non-maskable line, masking, acknowledge beating a same-cycle enable, and an ignored stray acknowledge. Random sequences are compared against a bench model of the captures, mask and enable.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NSRC   = 5;
  localparam int SRC_W  = 3;
  localparam int MASK_W = 3;

  localparam logic [SRC_W-1:0] SRC_NONE = 3'd0;
  localparam logic [SRC_W-1:0] SRC_NMI  = 3'd1;
  localparam logic [SRC_W-1:0] SRC_HI   = 3'd2;
  localparam logic [SRC_W-1:0] SRC_MID  = 3'd3;
  localparam logic [SRC_W-1:0] SRC_LO   = 3'd4;
  localparam logic [SRC_W-1:0] SRC_EXT  = 3'd5;

  // mask bit positions
  localparam int MB_HI  = 2;
  localparam int MB_MID = 1;
  localparam int MB_LO  = 0;
endpackage

// File: rtl/irqv_edge_cap.sv
module irqv_edge_cap #(
  parameter bit NEED_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic clr,
  output logic pend
);
  logic prev_q;
  logic hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      hold_q <= 1'b0;
    end else begin
      prev_q <= din;
      if (din && !prev_q)
        hold_q <= 1'b1;
      else if (clr)
        hold_q <= 1'b0;
    end
  end

  generate
    if (NEED_LEVEL) begin : g_qual
      assign pend = hold_q & din;
    end else begin : g_plain
      assign pend = hold_q;
    end
  endgenerate
endmodule

// File: rtl/irqv_resolver.sv
module irqv_resolver
  import irqv_pkg::*;
#(
  parameter int               VEC_W   = 16,
  parameter logic [VEC_W-1:0] VEC_NMI = 16'h0024,
  parameter logic [VEC_W-1:0] VEC_HI  = 16'h003C,
  parameter logic [VEC_W-1:0] VEC_MID = 16'h0034,
  parameter logic [VEC_W-1:0] VEC_LO  = 16'h002C
) (
  input  logic [NSRC-1:0]  req,
  input  logic [VEC_W-1:0] ext_vec,
  output logic             any,
  output logic [SRC_W-1:0] src,
  output logic [VEC_W-1:0] vec
);
  localparam logic [VEC_W-1:0] FIXED [NSRC-1] = '{VEC_NMI, VEC_HI, VEC_MID, VEC_LO};

  always_comb begin
    any = |req;
    src = SRC_NONE;
    vec = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        src = SRC_W'(i + 1);
        vec = (i == NSRC - 1) ? ext_vec : FIXED[i];
      end
    end
  end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irqv_pkg::*;
#(
  parameter int               VEC_W   = 16,
  parameter logic [VEC_W-1:0] VEC_NMI = 16'h0024,
  parameter logic [VEC_W-1:0] VEC_HI  = 16'h003C,
  parameter logic [VEC_W-1:0] VEC_MID = 16'h0034,
  parameter logic [VEC_W-1:0] VEC_LO  = 16'h002C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmi_in,
  input  logic              hi_edge_in,
  input  logic              mid_lvl_in,
  input  logic              lo_lvl_in,
  input  logic              ext_req_in,
  input  logic [VEC_W-1:0]  ext_vec_in,
  input  logic              mask_wr,
  input  logic [MASK_W-1:0] mask_data,
  input  logic              hi_edge_clr,
  input  logic              ie_set,
  input  logic              ie_clr,
  input  logic              ack_in,
  output logic              req_out,
  output logic [SRC_W-1:0]  src_out,
  output logic [VEC_W-1:0]  vec_out
);
  logic [MASK_W-1:0] mask_q;
  logic              ie_q;
  logic              ack_fire;
  logic              nmi_pend, hi_pend;
  logic [NSRC-1:0]   gated;
  logic              r_any;
  logic [SRC_W-1:0]  r_src;
  logic [VEC_W-1:0]  r_vec;

  assign ack_fire = ack_in & req_out;

  irqv_edge_cap #(.NEED_LEVEL(1'b1)) u_nmi_cap (
    .clk(clk), .rst(rst), .din(nmi_in),
    .clr(ack_fire && (src_out == SRC_NMI)), .pend(nmi_pend)
  );

  irqv_edge_cap #(.NEED_LEVEL(1'b0)) u_hi_cap (
    .clk(clk), .rst(rst), .din(hi_edge_in),
    .clr((ack_fire && (src_out == SRC_HI)) || hi_edge_clr), .pend(hi_pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      ie_q   <= 1'b0;
    end else begin
      if (mask_wr)
        mask_q <= mask_data;
      if (ack_fire || ie_clr)
        ie_q <= 1'b0;
      else if (ie_set)
        ie_q <= 1'b1;
    end
  end

  always_comb begin
    gated    = '0;
    gated[0] = nmi_pend;
    gated[1] = hi_pend    & ie_q & ~mask_q[MB_HI];
    gated[2] = mid_lvl_in & ie_q & ~mask_q[MB_MID];
    gated[3] = lo_lvl_in  & ie_q & ~mask_q[MB_LO];
    gated[4] = ext_req_in & ie_q;
  end

  irqv_resolver #(
    .VEC_W(VEC_W), .VEC_NMI(VEC_NMI), .VEC_HI(VEC_HI),
    .VEC_MID(VEC_MID), .VEC_LO(VEC_LO)
  ) u_res (
    .req(gated), .ext_vec(ext_vec_in),
    .any(r_any), .src(r_src), .vec(r_vec)
  );

  always_ff @(posedge clk) begin
    if (rst || ack_fire) begin
      req_out <= 1'b0;
      src_out <= SRC_NONE;
      vec_out <= '0;
    end else begin
      req_out <= r_any;
      src_out <= r_src;
      vec_out <= r_vec;
    end
  end
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker
  import irqv_pkg::*;
#(
  parameter int               VEC_W   = 16,
  parameter logic [VEC_W-1:0] VEC_NMI = 16'h0024,
  parameter logic [VEC_W-1:0] VEC_HI  = 16'h003C,
  parameter logic [VEC_W-1:0] VEC_MID = 16'h0034,
  parameter logic [VEC_W-1:0] VEC_LO  = 16'h002C
) (
  input logic             clk,
  input logic             rst,
  input logic             nmi_in,
  input logic             ack_in,
  input logic             req_out,
  input logic [SRC_W-1:0] src_out,
  input logic [VEC_W-1:0] vec_out
);
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!req_out && src_out == SRC_NONE && vec_out == '0));

  p_src_range_r2: assert property (@(posedge clk) disable iff (rst)
    req_out |-> (src_out >= SRC_NMI && src_out <= SRC_EXT));

  p_idle_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !req_out |-> (src_out == SRC_NONE && vec_out == '0));

  p_vec_nmi_r3: assert property (@(posedge clk) disable iff (rst)
    (req_out && src_out == SRC_NMI) |-> vec_out == VEC_NMI);

  p_vec_hi_r3: assert property (@(posedge clk) disable iff (rst)
    (req_out && src_out == SRC_HI) |-> vec_out == VEC_HI);

  p_vec_mid_r3: assert property (@(posedge clk) disable iff (rst)
    (req_out && src_out == SRC_MID) |-> vec_out == VEC_MID);

  p_vec_lo_r3: assert property (@(posedge clk) disable iff (rst)
    (req_out && src_out == SRC_LO) |-> vec_out == VEC_LO);

  p_nmi_level_r4: assert property (@(posedge clk) disable iff (rst)
    (req_out && src_out == SRC_NMI) |-> $past(nmi_in));

  p_ack_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (ack_in && req_out) |=> !req_out);

  p_ie_cleared_r9: assert property (@(posedge clk) disable iff (rst)
    (ack_in && req_out) |-> ##2 (!req_out || src_out == SRC_NMI));
endmodule

bind irq_vector_unit irqv_checker #(
  .VEC_W(VEC_W), .VEC_NMI(VEC_NMI), .VEC_HI(VEC_HI),
  .VEC_MID(VEC_MID), .VEC_LO(VEC_LO)
) u_chk (
  .clk(clk), .rst(rst), .nmi_in(nmi_in), .ack_in(ack_in),
  .req_out(req_out), .src_out(src_out), .vec_out(vec_out)
);

// File: tb/irq_vector_unit_test.sv
`timescale 1ns/1ps
module irq_vector_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        nmi_in = 0, hi_edge_in = 0, mid_lvl_in = 0, lo_lvl_in = 0, ext_req_in = 0;
  logic [15:0] ext_vec_in = '0;
  logic        mask_wr = 0;
  logic [2:0]  mask_data = '0;
  logic        hi_edge_clr = 0, ie_set = 0, ie_clr = 0, ack_in = 0;
  logic        req_out;
  logic [2:0]  src_out;
  logic [15:0] vec_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model state
  bit       m_nmi_arm = 0;
  bit       m_hi = 0;
  bit       m_ie = 0;
  bit [2:0] m_mask = 3'b111;

  always #2.5 clk = ~clk;

  irq_vector_unit uut (
    .clk(clk), .rst(rst), .nmi_in(nmi_in), .hi_edge_in(hi_edge_in),
    .mid_lvl_in(mid_lvl_in), .lo_lvl_in(lo_lvl_in), .ext_req_in(ext_req_in),
    .ext_vec_in(ext_vec_in), .mask_wr(mask_wr), .mask_data(mask_data),
    .hi_edge_clr(hi_edge_clr), .ie_set(ie_set), .ie_clr(ie_clr), .ack_in(ack_in),
    .req_out(req_out), .src_out(src_out), .vec_out(vec_out)
  );

  function automatic logic [2:0] exp_src();
    if (m_nmi_arm && nmi_in) return 3'd1;
    if (!m_ie) return 3'd0;
    if (m_hi && !m_mask[2]) return 3'd2;
    if (mid_lvl_in && !m_mask[1]) return 3'd3;
    if (lo_lvl_in && !m_mask[0]) return 3'd4;
    if (ext_req_in) return 3'd5;
    return 3'd0;
  endfunction

  function automatic logic [15:0] exp_vec(input logic [2:0] s);
    case (s)
      3'd1: return 16'h0024;
      3'd2: return 16'h003C;
      3'd3: return 16'h0034;
      3'd4: return 16'h002C;
      3'd5: return ext_vec_in;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string tag);
    logic [2:0] es;
    es = exp_src();
    checks++;
    if (req_out !== (es != 0) || src_out !== es || vec_out !== exp_vec(es)) begin
      errors++;
      $display("FAIL %s: got req=%0b src=%0d vec=%h, expected req=%0b src=%0d vec=%h",
               tag, req_out, src_out, vec_out, es != 0, es, exp_vec(es));
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic set_nmi(input bit v);
    @(negedge clk);
    if (v && !nmi_in) m_nmi_arm = 1;
    nmi_in = v;
  endtask

  task automatic pulse_hi();
    @(negedge clk); hi_edge_in = 1; m_hi = 1;
    @(negedge clk); hi_edge_in = 0;
  endtask

  task automatic pulse_clr_hi();
    @(negedge clk); hi_edge_clr = 1; m_hi = 0;
    @(negedge clk); hi_edge_clr = 0;
  endtask

  task automatic write_mask(input bit [2:0] v);
    @(negedge clk); mask_wr = 1; mask_data = v; m_mask = v;
    @(negedge clk); mask_wr = 0;
  endtask

  task automatic en_set();
    @(negedge clk); ie_set = 1; m_ie = 1;
    @(negedge clk); ie_set = 0;
  endtask

  task automatic en_clr();
    @(negedge clk); ie_clr = 1; m_ie = 0;
    @(negedge clk); ie_clr = 0;
  endtask

  // acknowledge, optionally together with ie_set; checks R10 drop
  task automatic do_ack(input bit with_set, input string tag);
    logic [2:0] es;
    @(negedge clk);
    es = exp_src();
    ack_in = 1; ie_set = with_set;
    if (es == 3'd1) m_nmi_arm = 0;
    if (es == 3'd2) m_hi = 0;
    if (es != 3'd0) m_ie = 0;
    else if (with_set) m_ie = 1;
    @(negedge clk);
    ack_in = 0; ie_set = 0;
    checks++;
    if (req_out !== 1'b0) begin
      errors++;
      $display("FAIL %s R10: req_out after ack got %0b expected 0", tag, req_out);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    chk("R1 in reset");
    rst = 0;
    settle();
    chk("R1 after reset");
    // R1: mask all set and enable clear: level lines do nothing
    lo_lvl_in = 1; settle(); chk("R1 reset mask/enable blocks");
    write_mask(3'b000); settle(); chk("R9 enable still clear");
    en_set(); settle(); chk("R7 low level request");
    mid_lvl_in = 1; settle(); chk("R2 mid over low");
    lo_lvl_in = 0; mid_lvl_in = 0; settle(); chk("R7 level gone");
    ext_vec_in = 16'h1234; ext_req_in = 1; settle(); chk("R3 external vector");
    mid_lvl_in = 1; lo_lvl_in = 1; write_mask(3'b011); settle(); chk("R8 mid/low masked, external shown");
    write_mask(3'b100); pulse_hi(); settle(); chk("R6 masked edge held back");
    write_mask(3'b000); settle(); chk("R6 captured edge after unmask R2");
    do_ack(0, "R6 ack edge line");
    settle(); chk("R9 enable cleared by ack");
    en_set(); settle(); chk("R6 capture cleared by ack");
    pulse_hi(); pulse_clr_hi(); settle(); chk("R6 software clear");
    mid_lvl_in = 0; lo_lvl_in = 0;
    do_ack(1, "R9 ack with ie_set");
    settle(); chk("R9 ack wins over ie_set");
    en_set(); ext_req_in = 0; settle();
    do_ack(0, "R10 stray ack");
    lo_lvl_in = 1; settle(); chk("R10 stray ack left enable set");
    lo_lvl_in = 0;
    en_clr(); write_mask(3'b111);
    set_nmi(1); set_nmi(0); settle(); chk("R4 nmi pulse already fallen");
    set_nmi(1); settle(); chk("R4 nmi unmaskable with enable clear");
    do_ack(0, "R5 ack nmi");
    settle(); chk("R5 held nmi no re-trigger");
    set_nmi(0); set_nmi(1); settle(); chk("R5 new nmi edge");
    do_ack(0, "R5 second ack");
    set_nmi(0); settle();

    for (int it = 0; it < 60; it++) begin
      mid_lvl_in = $urandom_range(0, 1);
      lo_lvl_in  = $urandom_range(0, 1);
      ext_req_in = $urandom_range(0, 1);
      ext_vec_in = 16'($urandom);
      if ($urandom_range(0, 3) == 0) set_nmi($urandom_range(0, 1));
      if ($urandom_range(0, 2) == 0) pulse_hi();
      if ($urandom_range(0, 7) == 0) pulse_clr_hi();
      if ($urandom_range(0, 2) == 0) write_mask(3'($urandom));
      if ($urandom_range(0, 1) == 0) en_set();
      if ($urandom_range(0, 7) == 0) en_clr();
      settle();
      chk("R2 random priority");
      if ($urandom_range(0, 1) == 0) begin
        do_ack($urandom_range(0, 1), "R10 random ack");
        settle();
        chk("R9 random after ack");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule